// File: doc/BRIEF.md
# Two-wire start detector with clock hold

This block is the slave-side front end of a two-wire serial bus. It brings the clock and data lines in through a two-flop synchronizer and compares each synchronized sample with the one before it. From that comparison it finds clock edges, start conditions (data falls while the clock is high) and stop conditions (data rises while the clock is high). A start sets a sticky flag, which can raise an interrupt request. When the master then pulls the clock low for the first time, the block keeps the clock low on its own. This gives software time to prepare for the address byte. The hold ends when software clears the start flag, which also zeroes the edge counter, or when a stop is seen.

An 8-bit shift register samples the data line into a one-bit latch on each rising clock edge. On each falling clock edge it shifts that latch into its least significant bit. Its most significant bit drives the data line. A 4-bit counter counts every clock edge and flags an overflow when it wraps. All line outputs are pull-low enables that model open-drain wiring, and each is gated by a direction bit. The block only detects and holds. Which way a byte travels, and what an address means, are decided by the protocol layer above it. One address frame is seven address bits, then a read/write bit on clock 8, then an acknowledge on clock 9.

The hold controller has three states. IDLE moves to ARMED on a start. ARMED moves to HOLD on a clock fall, returns to IDLE on a flag clear or a stop, and stays in ARMED on a repeated start. HOLD returns to IDLE on a flag clear or a stop, and moves to ARMED on a start.

Top module: `twi_start_hold`

## Requirements
- R1: After reset all flags are 0, the edge counter is 0, the shift register reads 8'hFF, and neither line is pulled low.
- R2: The start flag sets when, two clocks after the raw lines change, the synchronized SDA goes from 1 to 0 while SCL is 1 in both samples. An SDA fall while SCL is low does not set it. The flag stays set until `start_clr` is pulsed.
- R3: `irq` is high exactly while `irq_en` is 1 and the start flag is set.
- R4: After a start, the first synchronized SCL fall puts the controller in HOLD. In HOLD, `scl_pull` is 1 whenever `scl_dir` is 1, so the line stays low even after the master releases it.
- R5: A `start_clr` pulse in ARMED or HOLD returns the controller to IDLE and releases SCL. If it comes in the same cycle as an SCL fall in ARMED, the clear wins.
- R6: An SDA rise while SCL is high in both samples sets the sticky stop flag (cleared by `stop_clr`) and returns the controller to IDLE, so no hold follows.
- R7: `edge_cnt` increments on every synchronized SCL rise and fall. Going from 15 to 0 sets `ovf_flag`, which stays set until `ovf_clr` is pulsed. A new wrap in the same cycle as `ovf_clr` wins.
- R8: `cnt_clr` or `start_clr` zeroes the counter on the next edge, even if an SCL edge falls in the same cycle, and no overflow results.
- R9: On a rising SCL edge, SDA is captured into a latch. On a falling SCL edge, the register shifts left and takes the latch into bit 0. A `data_we` write loads `data_wdata` and wins over a same-cycle shift. `data_rdata` shows the register.
- R10: `sda_pull` = `sda_dir` AND (bit 7 of the register is 0 OR `sda_pin_low`). `scl_pull` is never 1 while `scl_dir` is 0.
- R11: When a start is detected in the same cycle as a `start_clr` pulse, the start wins: the flag stays set and the controller enters ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw clock line level |
| sda_i | input | 1 | Raw data line level |
| scl_dir | input | 1 | Enables the clock pull-low output |
| sda_dir | input | 1 | Enables the data pull-low output |
| sda_pin_low | input | 1 | Forces the data line low when enabled |
| irq_en | input | 1 | Start interrupt enable |
| start_clr | input | 1 | Clears the start flag and the counter, ends the hold |
| stop_clr | input | 1 | Clears the stop flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_clr | input | 1 | Zeroes the edge counter |
| data_we | input | 1 | Loads the shift register |
| data_wdata | input | 8 | Load value |
| data_rdata | output | 8 | Shift register contents |
| start_flag | output | 1 | Sticky start flag |
| stop_flag | output | 1 | Sticky stop flag |
| ovf_flag | output | 1 | Counter wrap flag |
| edge_cnt | output | 4 | Clock edge count |
| irq | output | 1 | Start interrupt request |
| scl_pull | output | 1 | Pull clock line low |
| sda_pull | output | 1 | Pull data line low |

## Verification
Two collisions are provoked on purpose. In the first, the bench times a `start_clr` pulse so that it reaches the flag register in the same cycle as a detected start. It expects the flag to stay set and a hold to follow the next clock fall. In the second, `cnt_clr` is held while SCL toggles every cycle, so a counter clear and an edge fall in the same cycle. The expected counter is zero and no overflow. A behavioural model that delays the line samples through a queue judges both cases on every clock.

// File: rtl/twi_sh_pkg.sv
package twi_sh_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ARMED = 2'd1,
        HS_HOLD  = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } line_ev_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_i[g]};
            end
        end
        assign sync_o[g] = chain[LAST];
    end

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_sh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);
    logic scl_prev;
    logic sda_prev;
    logic clk_high_both;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        clk_high_both = scl_prev & scl_s;
        ev.start      = clk_high_both & sda_prev & ~sda_s;
        ev.stop       = clk_high_both & ~sda_prev & sda_s;
        ev.scl_rise   = ~scl_prev & scl_s;
        ev.scl_fall   = scl_prev & ~scl_s;
    end

endmodule

// File: rtl/twi_hold_fsm.sv
module twi_hold_fsm
    import twi_sh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  line_ev_t ev,
    input  logic     start_clr,
    input  logic     stop_clr,
    output logic     start_flag,
    output logic     stop_flag,
    output logic     hold_scl
);
    hold_state_e state_q;
    hold_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (ev.start) state_d = HS_ARMED;
            end
            HS_ARMED: begin
                if (ev.start)          state_d = HS_ARMED;
                else if (ev.stop)      state_d = HS_IDLE;
                else if (start_clr)    state_d = HS_IDLE;
                else if (ev.scl_fall)  state_d = HS_HOLD;
            end
            HS_HOLD: begin
                if (ev.start)          state_d = HS_ARMED;
                else if (ev.stop)      state_d = HS_IDLE;
                else if (start_clr)    state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // sticky condition flags: a detection beats a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            if (ev.start)      start_flag <= 1'b1;
            else if (start_clr) start_flag <= 1'b0;
            if (ev.stop)       stop_flag  <= 1'b1;
            else if (stop_clr) stop_flag  <= 1'b0;
        end
    end

    // outputs from state
    always_comb begin
        hold_scl = 1'b0;
        unique case (state_q)
            HS_IDLE:  hold_scl = 1'b0;
            HS_ARMED: hold_scl = 1'b0;
            HS_HOLD:  hold_scl = 1'b1;
            default:  hold_scl = 1'b0;
        endcase
    end

endmodule

// File: rtl/twi_shift_count.sv
module twi_shift_count
    import twi_sh_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev,
    input  logic              sda_s,
    input  logic              cnt_zero,
    input  logic              ovf_clr,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_q
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic bit_latch;
    logic any_edge;
    logic wrap;

    assign any_edge = ev.scl_rise | ev.scl_fall;
    assign wrap     = any_edge & ~cnt_zero & (cnt_q == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_zero) begin
            cnt_q <= '0;
        end else if (any_edge) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           bit_latch <= 1'b1;
        else if (ev.scl_rise) bit_latch <= sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '1;
        end else if (data_we) begin
            data_q <= data_wdata;
        end else if (ev.scl_fall) begin
            data_q <= {data_q[DATA_W-2:0], bit_latch};
        end
    end

endmodule

// File: rtl/twi_start_hold.sv
module twi_start_hold
    import twi_sh_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              scl_dir,
    input  logic              sda_dir,
    input  logic              sda_pin_low,
    input  logic              irq_en,
    input  logic              start_clr,
    input  logic              stop_clr,
    input  logic              ovf_clr,
    input  logic              cnt_clr,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              start_flag,
    output logic              stop_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  edge_cnt,
    output logic              irq,
    output logic              scl_pull,
    output logic              sda_pull
);
    localparam int MSB = DATA_W - 1;

    logic [1:0] lines_s;
    line_ev_t   ev;
    logic       hold_scl;
    logic       cnt_zero;

    twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .sync_o (lines_s)
    );

    twi_cond_detect i_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[0]),
        .sda_s (lines_s[1]),
        .ev    (ev)
    );

    twi_hold_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .start_clr  (start_clr),
        .stop_clr   (stop_clr),
        .start_flag (start_flag),
        .stop_flag  (stop_flag),
        .hold_scl   (hold_scl)
    );

    assign cnt_zero = cnt_clr | start_clr;

    twi_shift_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .sda_s      (lines_s[1]),
        .cnt_zero   (cnt_zero),
        .ovf_clr    (ovf_clr),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .data_q     (data_rdata),
        .cnt_q      (edge_cnt),
        .ovf_q      (ovf_flag)
    );

    assign irq      = irq_en & start_flag;
    assign scl_pull = scl_dir & hold_scl;
    assign sda_pull = sda_dir & (~data_rdata[MSB] | sda_pin_low);

endmodule

// File: rtl/twi_start_hold_chk.sv
module twi_start_hold_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_dir,
    input logic             start_clr,
    input logic             cnt_clr,
    input logic             start_flag,
    input logic             stop_flag,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] edge_cnt,
    input logic             scl_pull
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !start_clr) |=> start_flag);

    a_r5_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> start_flag);

    a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> !scl_pull);

    a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_cnt) == TOP && edge_cnt == '0 && !$past(cnt_clr || start_clr))
        |-> ovf_flag);

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr || start_clr) |=> (edge_cnt == '0));

    a_r10_scl_dir_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_dir |-> !scl_pull);

endmodule

bind twi_start_hold twi_start_hold_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_dir    (scl_dir),
    .start_clr  (start_clr),
    .cnt_clr    (cnt_clr),
    .start_flag (start_flag),
    .stop_flag  (stop_flag),
    .ovf_flag   (ovf_flag),
    .edge_cnt   (edge_cnt),
    .scl_pull   (scl_pull)
);

// File: tb/test_twi_start_hold.sv
`timescale 1ns/1ps
module test_twi_start_hold;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mscl = 1'b1, msda = 1'b1;
    logic       scl_dir = 1'b1, sda_dir = 1'b0, sda_pin_low = 1'b0, irq_en = 1'b0;
    logic       start_clr = 1'b0, stop_clr = 1'b0, ovf_clr = 1'b0, cnt_clr = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic [7:0] data_rdata;
    logic       start_flag, stop_flag, ovf_flag, irq, scl_pull, sda_pull;
    logic [3:0] edge_cnt;
    logic       scl_line, sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    // wired-AND bus: the master and the block can only pull low
    assign scl_line = mscl & ~scl_pull;
    assign sda_line = msda & ~sda_pull;

    twi_start_hold i_twi_start_hold (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_dir(scl_dir), .sda_dir(sda_dir), .sda_pin_low(sda_pin_low),
        .irq_en(irq_en), .start_clr(start_clr), .stop_clr(stop_clr),
        .ovf_clr(ovf_clr), .cnt_clr(cnt_clr), .data_we(data_we),
        .data_wdata(data_wdata), .data_rdata(data_rdata),
        .start_flag(start_flag), .stop_flag(stop_flag), .ovf_flag(ovf_flag),
        .edge_cnt(edge_cnt), .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: the block reacts to the bus two clocks late
    bit   scl_h[$];
    bit   sda_h[$];
    int   m_phase;   // 0 idle, 1 armed, 2 holding
    bit   m_start, m_stop, m_ovf, m_latch;
    int   m_cnt;
    logic [7:0] m_sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_h = '{1, 1, 1}; sda_h = '{1, 1, 1};
            m_phase = 0; m_start = 0; m_stop = 0; m_ovf = 0; m_latch = 1;
            m_cnt = 0; m_sh = 8'hFF;
        end else begin
            bit cs, ps, cd, pd, st, sp, rise, fall, wrapped;
            cs = scl_h[1]; ps = scl_h[2]; cd = sda_h[1]; pd = sda_h[2];
            st   = ps && cs && pd && !cd;
            sp   = ps && cs && !pd && cd;
            rise = !ps && cs;
            fall = ps && !cs;
            if (st)                                    m_phase = 1;
            else if (sp)                               m_phase = 0;
            else if (m_phase != 0 && start_clr)        m_phase = 0;
            else if (m_phase == 1 && fall)             m_phase = 2;
            if (st) m_start = 1; else if (start_clr) m_start = 0;
            if (sp) m_stop = 1;  else if (stop_clr)  m_stop = 0;
            wrapped = 0;
            if (cnt_clr || start_clr) m_cnt = 0;
            else if (rise || fall) begin
                if (m_cnt == 15) begin m_cnt = 0; wrapped = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wrapped) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
            if (data_we) m_sh = data_wdata;
            else if (fall) m_sh = {m_sh[6:0], m_latch};
            if (rise) m_latch = cd;
            scl_h.push_front(scl_line); void'(scl_h.pop_back());
            sda_h.push_front(sda_line); void'(sda_h.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 start flag", start_flag, m_start);
            chk("R3 irq", irq, irq_en & m_start);
            chk("R6 stop flag", stop_flag, m_stop);
            chk("R7 overflow", ovf_flag, m_ovf);
            chk("R7 R8 counter", edge_cnt, m_cnt);
            chk("R9 shift data", data_rdata, m_sh);
            chk("R4 R5 scl pull", scl_pull, scl_dir & (m_phase == 2));
            chk("R10 sda pull", sda_pull, sda_dir & (!m_sh[7] | sda_pin_low));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; tick(1); s = 1'b0;
    endtask

    task automatic send_bit(input bit b);
        msda = b; tick(4); mscl = 1'b1; tick(4); mscl = 1'b0; tick(4);
    endtask

    task automatic mid_check(input string req, input int act, input int exp);
        @(negedge clk); chk(req, act, exp); @(posedge clk); #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {start_flag, stop_flag, ovf_flag}, 0);
        chk("R1 counter", edge_cnt, 0);
        chk("R1 data", data_rdata, 8'hFF);
        chk("R1 pulls", {scl_pull, sda_pull}, 0);
        @(posedge clk); #1;

        // R2: SDA fall while SCL low is not a start
        mscl = 0; tick(4); msda = 0; tick(4); msda = 1; tick(4); mscl = 1; tick(5);
        mid_check("R2 no start with scl low", start_flag, 0);

        // R2 R3 R4: real start, then master fall, then held
        irq_en = 1; msda = 0; tick(5);
        mid_check("R3 irq after start", irq, 1);
        mscl = 0; tick(6); mscl = 1; tick(8);
        mid_check("R4 line held low", scl_line, 0);
        pulse(start_clr); tick(6);
        mid_check("R5 line released", scl_line, 1);

        // R9 R7: master sends a byte
        mscl = 0; tick(4);
        for (int i = 7; i >= 0; i--) send_bit(8'hA6 >> i);
        mid_check("R9 received byte", data_rdata, 8'hA6);
        mid_check("R7 overflow after 16 edges", ovf_flag, 1);
        send_bit(0);
        pulse(ovf_clr); tick(2);

        // R8: counter clear colliding with edges every cycle
        for (int i = 0; i < 12; i++) begin
            mscl = ~mscl;
            cnt_clr = (i >= 4 && i < 7);
            tick(1);
        end
        cnt_clr = 0; mscl = 0; tick(5);

        // R10: slave transmit
        msda = 1; sda_dir = 1; data_wdata = 8'h5A; pulse(data_we); tick(1);
        mid_check("R10 msb zero pulls sda", sda_pull, 1);
        for (int i = 0; i < 4; i++) send_bit(1);
        sda_pin_low = 1; tick(1);
        mid_check("R10 pin force", sda_pull, 1);
        sda_pin_low = 0; data_wdata = 8'hFF; pulse(data_we); sda_dir = 0; tick(4);

        // R6: stop
        msda = 0; tick(4); mscl = 1; tick(4); msda = 1; tick(5);
        mid_check("R6 stop flag", stop_flag, 1);
        pulse(stop_clr); pulse(start_clr); tick(3);

        // R6: stop while armed prevents a hold
        msda = 0; tick(5); msda = 1; tick(5); mscl = 0; tick(6);
        mid_check("R6 no hold after stop", scl_pull, 0);
        pulse(start_clr); mscl = 1; tick(5);

        // R11: start and clear arrive in the same cycle
        msda = 0; tick(2); pulse(start_clr); tick(2);
        mid_check("R11 start beats clear", start_flag, 1);
        mscl = 0; tick(6);
        mid_check("R11 hold follows", scl_line, 0);

        // R10: direction gate on the clock hold
        scl_dir = 0; tick(1);
        mid_check("R10 scl gated", scl_pull, 0);
        scl_dir = 1; tick(1);
        mid_check("R4 hold resumes", scl_pull, 1);
        pulse(start_clr); mscl = 1; tick(4); msda = 1; tick(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule